// File: doc/BRIEF.md
# Privilege-Gated Auxiliary Control Register

This block holds one 32-bit word of auxiliary configuration for a cache and memory subsystem, reached through a simple CSR-style request port. Each request carries the requester's privilege level (0 to 3) and its security state. The block decides from these, together with two delegation enables supplied by the higher privilege levels and a secure-configuration flag, whether the request may read or write. A single copy of the word serves both security states. The value is presented continuously on `cfg_value` for the downstream logic, which decodes the fields.

Several bit positions are unimplemented: they always read zero and drop written data. The reset value depends partly on a strap that names which of two coherent interconnect protocols the subsystem uses. Because the word may only change while the memory system is quiet, a permitted write takes effect only while `mem_idle` is high. A permitted write that arrives while it is low produces a one-cycle busy error instead. A request that fails the privilege check produces a one-cycle fault, returns zero data and changes nothing.

Top module: `aux_ctrl_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the word loads its reset value. Bit 4 is 1. Bits 14 and 3 both equal `proto_sel` (0 selects the first protocol, 1 selects the second). Every other bit is 0. The reset word is therefore 0x00000010 or 0x00004018.
- R2: Bits 31, 30, 29, 24, 12, 9 and 5 always read 0 and ignore written data, so writing 0xFFFFFFFF yields 0x1EFFEDDF.
- R3: Any request at level 0 (`req_el`=0) is denied.
- R4: Levels 2 and 3 may read and write in either security state, whatever the delegation inputs are.
- R5: Level 1 may always read. A secure level-1 write is permitted only when `deleg_l3` is 1.
- R6: A non-secure level-1 write (`req_secure`=0) is permitted only when `deleg_l3` is 1 and at least one of `deleg_l2` or `scr_secure` is 1.
- R7: A denied request gives `rsp_fault`=1 and `rsp_rdata`=0 in the response cycle, and leaves the word unchanged.
- R8: A permitted write while `mem_idle` is 0 gives `rsp_busy_err`=1 for one cycle and leaves the word unchanged. It does not give `rsp_fault`.
- R9: Every request gets `rsp_valid`=1 on the cycle after it is presented. A permitted read returns the word as it stood when the request was presented. Writes return 0 data.
- R10: A permitted write while `mem_idle` is 1 stores the data (masked as in R2). The new value appears on `cfg_value` one cycle later and is the same word seen from both security states.
- R11: `rsp_fault` and `rsp_busy_err` are never high together, and each is high only in response to a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_sel | input | 1 | Interconnect protocol strap (0 first, 1 second) |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_el | input | 2 | Requester privilege level 0..3 |
| req_secure | input | 1 | Requester is in the secure state |
| req_wdata | input | 32 | Write data |
| deleg_l3 | input | 1 | Level-3 delegation enable |
| deleg_l2 | input | 1 | Level-2 delegation enable |
| scr_secure | input | 1 | Secure-configuration flag says secure |
| mem_idle | input | 1 | Memory system idle |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and denials |
| rsp_fault | output | 1 | One-cycle privilege fault |
| rsp_busy_err | output | 1 | One-cycle write-while-busy error |
| cfg_value | output | 32 | Current register word for downstream logic |

## Verification
A wrong stored bit shows on `cfg_value` one cycle after the write or reset that caused it. It also shows in the next permitted read response. A reserved bit that holds state, or a reset bit tied to the wrong strap, is therefore visible within one cycle. A wrong permission decision shows in the very next response cycle as a fault that is present when it should be absent, or absent when it should be present. A write that slipped past the idle gate or the permission gate shows one cycle later as a changed `cfg_value`. This mix of random and directed traffic checks every one of these ports after every request.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;
  localparam int unsigned AUX_W = 32;

  typedef enum logic [1:0] {
    LVL_APP = 2'd0,
    LVL_OS  = 2'd1,
    LVL_HYP = 2'd2,
    LVL_MON = 2'd3
  } priv_lvl_e;

  // unimplemented positions: 31..29, 24, 12, 9, 5
  localparam logic [AUX_W-1:0] DEF_RSV_MASK   = 32'hE100_1220;
  // fixed reset ones (bit 4)
  localparam logic [AUX_W-1:0] DEF_RST_BASE   = 32'h0000_0010;
  // reset ones that follow the protocol strap (bits 14 and 3)
  localparam logic [AUX_W-1:0] DEF_PROTO_MASK = 32'h0000_4008;
endpackage

// File: rtl/aux_access_gate.sv
module aux_access_gate
  import aux_ctrl_pkg::*;
(
  input  logic [1:0] el,
  input  logic       secure,
  input  logic       write,
  input  logic       deleg_l3,
  input  logic       deleg_l2,
  input  logic       scr_secure,
  output logic       allow
);
  priv_lvl_e lvl;
  logic      os_wr_ok;

  assign lvl = priv_lvl_e'(el);

  always_comb begin
    if (secure) os_wr_ok = deleg_l3;
    else        os_wr_ok = deleg_l3 & (deleg_l2 | scr_secure);
  end

  always_comb begin
    unique case (lvl)
      LVL_APP: allow = 1'b0;
      LVL_OS:  allow = write ? os_wr_ok : 1'b1;
      LVL_HYP: allow = 1'b1;
      LVL_MON: allow = 1'b1;
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/aux_bit_store.sv
module aux_bit_store #(
  parameter int unsigned      W          = 32,
  parameter logic [W-1:0]     RSV_MASK   = '0,
  parameter logic [W-1:0]     RST_BASE   = '0,
  parameter logic [W-1:0]     PROTO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         proto_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] IMPL_MASK = ~RSV_MASK;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (RSV_MASK[b]) begin : g_rsv
      assign q[b] = 1'b0;
    end else begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)        bit_q <= RST_BASE[b] | (PROTO_MASK[b] & proto_sel);
        else if (wr_en) bit_q <= wdata[b];
      end
      assign q[b] = bit_q;
    end
  end

  // R10: the word moves only on an accepted write
  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
  // R2: unimplemented positions never hold a one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg
  import aux_ctrl_pkg::*;
#(
  parameter int unsigned          W          = AUX_W,
  parameter logic [W-1:0]         RSV_MASK   = DEF_RSV_MASK,
  parameter logic [W-1:0]         RST_BASE   = DEF_RST_BASE,
  parameter logic [W-1:0]         PROTO_MASK = DEF_PROTO_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         proto_sel,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [1:0]   req_el,
  input  logic         req_secure,
  input  logic [W-1:0] req_wdata,
  input  logic         deleg_l3,
  input  logic         deleg_l2,
  input  logic         scr_secure,
  input  logic         mem_idle,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata,
  output logic         rsp_fault,
  output logic         rsp_busy_err,
  output logic [W-1:0] cfg_value
);
  logic allow;
  logic wr_commit;
  logic wr_blocked;
  logic rd_hit;

  aux_access_gate u_gate (
    .el         (req_el),
    .secure     (req_secure),
    .write      (req_write),
    .deleg_l3   (deleg_l3),
    .deleg_l2   (deleg_l2),
    .scr_secure (scr_secure),
    .allow      (allow)
  );

  assign wr_commit  = req_valid & req_write & allow & mem_idle;
  assign wr_blocked = req_valid & req_write & allow & ~mem_idle;
  assign rd_hit     = req_valid & ~req_write & allow;

  aux_bit_store #(
    .W          (W),
    .RSV_MASK   (RSV_MASK),
    .RST_BASE   (RST_BASE),
    .PROTO_MASK (PROTO_MASK)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .proto_sel (proto_sel),
    .wr_en     (wr_commit),
    .wdata     (req_wdata),
    .q         (cfg_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_busy_err <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_fault    <= req_valid & ~allow;
      rsp_busy_err <= wr_blocked;
      rsp_rdata    <= rd_hit ? cfg_value : '0;
    end
  end

  // R3: level 0 always faults in the next cycle
  a_r3_level0_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_el == 2'd0) |=> rsp_fault);
  // R8: a write while busy leaves the word alone
  a_r8_busy_keeps_word: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !mem_idle) |=> $stable(cfg_value));
  // R7: a fault carries zero data
  a_r7_fault_zero_data: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_rdata == '0);
  // R11: the two error pulses are exclusive and come with a response
  a_r11_errors_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_fault && rsp_busy_err));
  a_r11_error_needs_rsp: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault || rsp_busy_err) |-> rsp_valid);
  // R9: every request is answered in the next cycle
  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
endmodule

// File: tb/aux_ctrl_reg_tb.sv
module aux_ctrl_reg_tb_top;
  localparam logic [31:0] IMPL = 32'h1EFF_EDDF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        proto_sel = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [1:0]  req_el = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        deleg_l3 = 1'b0, deleg_l2 = 1'b0, scr_secure = 1'b0, mem_idle = 1'b1;
  logic        rsp_valid, rsp_fault, rsp_busy_err;
  logic [31:0] rsp_rdata, cfg_value;

  int unsigned n_cmp = 0, n_bad = 0;
  logic [31:0] model;
  bit done = 1'b0;

  always #10 clk = ~clk;

  aux_ctrl_reg dut_i (
    .clk(clk), .rst(rst), .proto_sel(proto_sel), .req_valid(req_valid),
    .req_write(req_write), .req_el(req_el), .req_secure(req_secure),
    .req_wdata(req_wdata), .deleg_l3(deleg_l3), .deleg_l2(deleg_l2),
    .scr_secure(scr_secure), .mem_idle(mem_idle), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .rsp_busy_err(rsp_busy_err),
    .cfg_value(cfg_value)
  );

  function automatic logic f_allow(logic [1:0] el, logic sec, logic wr,
                                   logic l3, logic l2, logic scr);
    if (el == 2'd0) return 1'b0;
    if (el >= 2'd2) return 1'b1;
    if (!wr) return 1'b1;
    if (sec) return l3;
    return l3 & (l2 | scr);
  endfunction

  function automatic logic [31:0] f_reset(logic p);
    return 32'h10 | (p ? 32'h4008 : 32'h0);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(logic p);
    @(negedge clk);
    rst = 1'b1; proto_sel = p; req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model = f_reset(p);
    check("R1", "reset word", cfg_value, model);
    check("R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic acc(string tag, logic [1:0] el, logic sec, logic wr, logic [31:0] d,
                     logic idle, logic l3, logic l2, logic scr);
    logic ok;
    logic [31:0] exp_rd;
    req_valid = 1'b1; req_el = el; req_secure = sec; req_write = wr; req_wdata = d;
    mem_idle = idle; deleg_l3 = l3; deleg_l2 = l2; scr_secure = scr;
    ok = f_allow(el, sec, wr, l3, l2, scr);
    exp_rd = (!wr && ok) ? model : 32'd0;
    if (wr && ok && idle) model = d & IMPL;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(tag, "rsp_fault", {31'd0, rsp_fault}, {31'd0, !ok});
    check(tag, "rsp_busy_err", {31'd0, rsp_busy_err}, {31'd0, wr && ok && !idle});
    check(tag, "rsp_rdata", rsp_rdata, exp_rd);
    check(tag, "cfg_value", cfg_value, model);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    acc("R9", 2'd1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    do_reset(1'b1);
    acc("R9", 2'd3, 1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2 all ones
    acc("R2", 2'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2", "masked word", cfg_value, 32'h1EFF_EDDF);
    // R3 level 0 read and write
    acc("R3", 2'd0, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1);
    acc("R3", 2'd0, 1'b0, 1'b1, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R4 level 2 non-secure, no delegation
    acc("R4", 2'd2, 1'b0, 1'b1, 32'h0000_00A5, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5 secure level 1
    acc("R5", 2'd1, 1'b1, 1'b1, 32'h0800_0000, 1'b1, 1'b0, 1'b1, 1'b1);
    acc("R5", 2'd1, 1'b1, 1'b1, 32'h0800_0000, 1'b1, 1'b1, 1'b0, 1'b0);
    // R6 non-secure level 1
    acc("R6", 2'd1, 1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 1'b0);
    acc("R6", 2'd1, 1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 1'b1, 1'b1);
    acc("R6", 2'd1, 1'b0, 1'b1, 32'h0000_0002, 1'b1, 1'b1, 1'b1, 1'b0);
    acc("R6", 2'd1, 1'b0, 1'b1, 32'h0000_0004, 1'b1, 1'b1, 1'b0, 1'b1);
    // R7 denied write leaves word
    acc("R7", 2'd1, 1'b0, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8 busy write
    acc("R8", 2'd3, 1'b0, 1'b1, 32'h0FFF_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    // R10 shared copy: write secure, read non-secure level 1
    acc("R10", 2'd3, 1'b1, 1'b1, 32'h1C00_C003, 1'b1, 1'b0, 1'b0, 1'b0);
    acc("R10", 2'd1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R11 random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      acc("R11", r[1:0], r[2], r[3], $urandom, r[4] | r[5], r[6], r[7], r[8]);
      if (r[12:9] == 4'd0) begin
        @(negedge clk);
        check("R11", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R11", "idle fault", {31'd0, rsp_fault | rsp_busy_err}, 32'd0);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule